// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Alarm

This block keeps wall-clock time for a chip. A one-second strobe from an external divider advances a seconds counter. Carries then ripple into minutes and hours, which are kept as two-digit BCD, and into a binary day count. Software reads and writes every counter byte through a byte-wide register port, and it gates counting with a run bit in a control register.

An alarm compares the current minute, hour and day against three programmable alarm fields. Each field has its own enable. When every enabled comparison first becomes true after a count update, a sticky flag is set. The flag drives an interrupt output when the interrupt enable is set. The carry ripple happens in a single update cycle, and a busy bit marks that cycle. A time write that lands in the busy cycle is held and applied in the next cycle, so the write is not lost.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes are two-digit BCD values from 00 to 59. A low digit of 9 carries into the high digit, and 59 wraps to 00 with a carry into the next field.
- R2: Hours are BCD from 00 to 23. A wrap from 23 to 00 adds one to the day count.
- R3: After a one-cycle tick is accepted, control bit 7 (busy, read-only) reads 1 for exactly one cycle. The counters hold their new values from the following cycle.
- R4: The counters advance only while control bit 0 (run) is 1. A tick with run at 0 changes nothing.
- R5: The day count is a 15-bit binary value. Address 0x18 holds bits 7:0 and address 0x19 holds bits 14:8. Bit 7 at 0x19 reads 0 and ignores writes. The count wraps from 0x7FFF to 0.
- R6: The register addresses are: 0x14 control, 0x15 seconds, 0x16 minutes, 0x17 hours, 0x18 and 0x19 day, 0x1A alarm minute, 0x1B alarm hour, 0x1C and 0x1D alarm day (low, then high). Any other address reads 0.
- R7: A write to a time register (0x15 to 0x19) in the busy cycle is applied one cycle later. The written value therefore replaces the result of the increment.
- R8: The alarm matches when every enabled field equals its alarm register. Control bit 3 enables the minute compare, bit 4 the hour compare and bit 5 the day compare. Seconds are never compared. With no field enabled, the alarm never matches.
- R9: The alarm flag (control bit 2) is set on the update at which the match turns from false to true. It is not set again by later updates while the match persists.
- R10: Writing 1 to control bit 2 clears the alarm flag. Writing 0 to that bit leaves the flag unchanged.
- R11: The interrupt output is the alarm flag ANDed with control bit 1 (interrupt enable).
- R12: Reset clears all counters, all alarm registers, the control bits and the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest situation to reach from the ports is a time write that coincides with the single busy cycle. The tick is a short pulse, so the collision only happens if the write strobe is placed exactly one clock after the tick. The bench raises the tick at a falling edge, drops it at the next falling edge and presents the seconds write in that same instant, so the write overlaps the busy cycle. It then reads the seconds back after the deferred write has landed. A second hard case is the "only once" rule of the alarm. The bench sets the flag, clears it while the match still holds and ticks again, to show that a continuing match does not set the flag a second time.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam logic [7:0] A_CTRL  = 8'h14;
  localparam logic [7:0] A_SEC   = 8'h15;
  localparam logic [7:0] A_MIN   = 8'h16;
  localparam logic [7:0] A_HOUR  = 8'h17;
  localparam logic [7:0] A_DLO   = 8'h18;
  localparam logic [7:0] A_DHI   = 8'h19;
  localparam logic [7:0] A_AMIN  = 8'h1A;
  localparam logic [7:0] A_AHOUR = 8'h1B;
  localparam logic [7:0] A_ADLO  = 8'h1C;
  localparam logic [7:0] A_ADHI  = 8'h1D;

  localparam logic [7:0] SEC_TOP  = 8'h59;
  localparam logic [7:0] MIN_TOP  = 8'h59;
  localparam logic [7:0] HOUR_TOP = 8'h23;

  typedef enum logic [2:0] {F_SEC, F_MIN, F_HOUR, F_DLO, F_DHI, F_NONE} tfield_e;

  // {carry, next} for a two-digit BCD field that wraps after top
  function automatic logic [8:0] bcd_adv(input logic [7:0] v, input logic [7:0] top);
    if (v == top) return 9'h100;
    if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/cal_count.sv
module cal_count import cal_pkg::*; #(
  parameter int DAY_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                run,
  input  logic                wr_en,
  input  tfield_e             wr_sel,
  input  logic [7:0]          wr_data,
  output logic [7:0]          sec_o,
  output logic [7:0]          min_o,
  output logic [7:0]          hour_o,
  output logic [DAY_BITS-1:0] day_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int NF   = 5;
  localparam int HI_W = DAY_BITS - 8;

  logic [7:0]          sec_q, min_q, hour_q;
  logic [DAY_BITS-1:0] day_q, d_n;
  logic                busy_q, done_q, dv_q;
  tfield_e             dsel_q;
  logic [7:0]          ddat_q;
  logic [8:0]          s_n, m_n, h_n;
  logic [NF-1:0]       fwe;
  logic [7:0]          fdat [NF];

  always_comb begin
    s_n = bcd_adv(sec_q, SEC_TOP);
    m_n = bcd_adv(min_q, MIN_TOP);
    h_n = bcd_adv(hour_q, HOUR_TOP);
    d_n = (day_q == '1) ? '0 : day_q + 1'b1;
  end

  // a live write and a held write may hit different fields in one cycle
  always_comb begin
    for (int i = 0; i < NF; i++) begin
      fwe[i]  = (wr_en && wr_sel == tfield_e'(3'(i))) || (dv_q && dsel_q == tfield_e'(3'(i)));
      fdat[i] = (wr_en && wr_sel == tfield_e'(3'(i))) ? wr_data : ddat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hour_q <= '0; day_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; dv_q <= 1'b0;
      dsel_q <= F_NONE; ddat_q <= '0;
    end else begin
      busy_q <= tick & run & ~busy_q;
      done_q <= busy_q;
      if (busy_q) begin
        sec_q <= s_n[7:0];
        if (s_n[8]) min_q <= m_n[7:0];
        if (s_n[8] & m_n[8]) hour_q <= h_n[7:0];
        if (s_n[8] & m_n[8] & h_n[8]) day_q <= d_n;
        dv_q <= wr_en;
        if (wr_en) begin
          dsel_q <= wr_sel;
          ddat_q <= wr_data;
        end
      end else begin
        dv_q <= 1'b0;
        if (fwe[0]) sec_q  <= fdat[0];
        if (fwe[1]) min_q  <= fdat[1];
        if (fwe[2]) hour_q <= fdat[2];
        if (fwe[3]) day_q[7:0] <= fdat[3];
        if (fwe[4]) day_q[DAY_BITS-1:8] <= fdat[4][HI_W-1:0];
      end
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign day_o  = day_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r3_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sec_q == 8'h59) |=> (sec_q == 8'h00));
  a_r5_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23 && day_q == '1)
      |=> (day_q == '0));
  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !run && !wr_en && !dv_q)
      |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(day_q)));
  a_r7_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> dv_q);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int DAY_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [7:0]          cur_min,
  input  logic [7:0]          cur_hour,
  input  logic [DAY_BITS-1:0] cur_day,
  input  logic                men,
  input  logic                hen,
  input  logic                den,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [7:0]          wr_data,
  input  logic                flag_clr,
  output logic [7:0]          amin_o,
  output logic [7:0]          ahour_o,
  output logic [DAY_BITS-1:0] aday_o,
  output logic                flag_o
);
  localparam int HI_W = DAY_BITS - 8;

  logic [7:0]          amin_q, ahour_q;
  logic [DAY_BITS-1:0] aday_q;
  logic                flag_q, last_q, match, hit;

  assign match = (men | hen | den)
               & (!men || cur_min  == amin_q)
               & (!hen || cur_hour == ahour_q)
               & (!den || cur_day  == aday_q);
  assign hit = done & match & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amin_q <= '0; ahour_q <= '0; aday_q <= '0;
      flag_q <= 1'b0; last_q <= 1'b0;
    end else begin
      if (done) last_q <= match;
      flag_q <= hit | (flag_q & ~flag_clr);
      if (wr_en) begin
        case (wr_sel)
          2'd0: amin_q  <= wr_data;
          2'd1: ahour_q <= wr_data;
          2'd2: aday_q[7:0] <= wr_data;
          default: aday_q[DAY_BITS-1:8] <= wr_data[HI_W-1:0];
        endcase
      end
    end
  end

  assign amin_o  = amin_q;
  assign ahour_o = ahour_q;
  assign aday_o  = aday_q;
  assign flag_o  = flag_q;

  a_r9_flag_rises_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(done) && $past(match)));
  a_r10_clear_wins_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !done) |=> !flag_q);
  a_r8_no_enable_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!men && !hen && !den && !flag_q) |=> !flag_q);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import cal_pkg::*; #(
  parameter int DAY_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       alarm_irq
);
  logic                run_q, ien_q, men_q, hen_q, den_q;
  logic [7:0]          c_sec, c_min, c_hour, a_min, a_hour;
  logic [DAY_BITS-1:0] c_day, a_day;
  logic                busy, done, flag;
  tfield_e             tsel;
  logic                t_we, a_hit, a_we, ctrl_we, flag_clr;
  logic [1:0]          asel;

  always_comb begin
    tsel = F_NONE;
    a_hit = 1'b0;
    asel = 2'd0;
    case (bus_addr)
      A_SEC:   tsel = F_SEC;
      A_MIN:   tsel = F_MIN;
      A_HOUR:  tsel = F_HOUR;
      A_DLO:   tsel = F_DLO;
      A_DHI:   tsel = F_DHI;
      A_AMIN:  begin a_hit = 1'b1; asel = 2'd0; end
      A_AHOUR: begin a_hit = 1'b1; asel = 2'd1; end
      A_ADLO:  begin a_hit = 1'b1; asel = 2'd2; end
      A_ADHI:  begin a_hit = 1'b1; asel = 2'd3; end
      default: ;
    endcase
  end

  assign t_we     = bus_we && (tsel != F_NONE);
  assign a_we     = bus_we && a_hit;
  assign ctrl_we  = bus_we && (bus_addr == A_CTRL);
  assign flag_clr = ctrl_we && bus_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; ien_q <= 1'b0; men_q <= 1'b0; hen_q <= 1'b0; den_q <= 1'b0;
    end else if (ctrl_we) begin
      run_q <= bus_wdata[0];
      ien_q <= bus_wdata[1];
      men_q <= bus_wdata[3];
      hen_q <= bus_wdata[4];
      den_q <= bus_wdata[5];
    end
  end

  cal_count #(.DAY_BITS(DAY_BITS)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .run(run_q),
    .wr_en(t_we), .wr_sel(tsel), .wr_data(bus_wdata),
    .sec_o(c_sec), .min_o(c_min), .hour_o(c_hour), .day_o(c_day),
    .busy_o(busy), .done_o(done)
  );

  cal_alarm #(.DAY_BITS(DAY_BITS)) u_alarm (
    .clk(clk), .rst_n(rst_n), .done(done),
    .cur_min(c_min), .cur_hour(c_hour), .cur_day(c_day),
    .men(men_q), .hen(hen_q), .den(den_q),
    .wr_en(a_we), .wr_sel(asel), .wr_data(bus_wdata), .flag_clr(flag_clr),
    .amin_o(a_min), .ahour_o(a_hour), .aday_o(a_day), .flag_o(flag)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {busy, 1'b0, den_q, hen_q, men_q, flag, ien_q, run_q};
      A_SEC:   bus_rdata = c_sec;
      A_MIN:   bus_rdata = c_min;
      A_HOUR:  bus_rdata = c_hour;
      A_DLO:   bus_rdata = c_day[7:0];
      A_DHI:   bus_rdata = 8'(c_day >> 8);
      A_AMIN:  bus_rdata = a_min;
      A_AHOUR: bus_rdata = a_hour;
      A_ADLO:  bus_rdata = a_day[7:0];
      A_ADHI:  bus_rdata = 8'(a_day >> 8);
      default: bus_rdata = 8'h00;
    endcase
  end

  assign alarm_irq = flag & ien_q;

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> bus_rdata[2] || bus_addr != A_CTRL);
  a_r5_day_hi_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DHI) |-> !bus_rdata[7]);
endmodule

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       alarm_irq;
  int         n_chk = 0;
  int         n_err = 0;
  bit         ended = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  // tick, then wait for the update edge and the alarm edge
  task automatic tick1();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [15:0] d);
    wr(8'h15, s); wr(8'h16, m); wr(8'h17, h); wr(8'h18, d[7:0]); wr(8'h19, d[15:8]);
  endtask

  task automatic t_reset();
    for (int a = 8'h14; a <= 8'h1D; a++) rd_chk("R12 reset value", 8'(a), 8'h00);
    n_chk++;
    if (alarm_irq !== 1'b0) begin n_err++; $display("FAIL R12 irq got %b expected 0", alarm_irq); end
    rd_chk("R6 unmapped read", 8'h00, 8'h00);
    rd_chk("R6 unmapped read", 8'h1E, 8'h00);
  endtask

  task automatic t_stopped();
    set_time(8'h00, 8'h00, 8'h10, 16'h0000);
    tick1();
    rd_chk("R4 no count when run=0", 8'h15, 8'h10);
  endtask

  task automatic t_bcd();
    wr(8'h14, 8'h01);
    set_time(8'h00, 8'h00, 8'h00, 16'h0000);
    tick1();
    rd_chk("R1 seconds +1", 8'h15, 8'h01);
    wr(8'h15, 8'h09);
    tick1();
    rd_chk("R1 digit carry", 8'h15, 8'h10);
    set_time(8'h22, 8'h59, 8'h59, 16'h0000);
    tick1();
    rd_chk("R1 sec wrap", 8'h15, 8'h00);
    rd_chk("R1 min wrap", 8'h16, 8'h00);
    rd_chk("R2 hour step", 8'h17, 8'h23);
    rd_chk("R2 day untouched", 8'h18, 8'h00);
  endtask

  task automatic t_cascade();
    set_time(8'h23, 8'h59, 8'h59, 16'h00FF);
    tick1();
    rd_chk("R2 hour wrap", 8'h17, 8'h00);
    rd_chk("R5 day low wrap", 8'h18, 8'h00);
    rd_chk("R5 day high carry", 8'h19, 8'h01);
    wr(8'h19, 8'hFF);
    rd_chk("R5 day high bit7 ignored", 8'h19, 8'h7F);
    set_time(8'h23, 8'h59, 8'h59, 16'h7FFF);
    tick1();
    rd_chk("R5 max wrap low", 8'h18, 8'h00);
    rd_chk("R5 max wrap high", 8'h19, 8'h00);
  endtask

  task automatic t_busy_defer();
    set_time(8'h01, 8'h02, 8'h20, 16'h0000);
    @(negedge clk); sec_tick = 1'b1; bus_addr = 8'h14;
    @(negedge clk); sec_tick = 1'b0;
    #1 chk("R3 busy set", bus_rdata & 8'h80, 8'h80);
    @(negedge clk);
    #1 chk("R3 busy one cycle", bus_rdata & 8'h80, 8'h00);
    rd_chk("R3 counted", 8'h15, 8'h21);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    bus_we = 1'b1; bus_addr = 8'h15; bus_wdata = 8'h45;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk);
    rd_chk("R7 held write wins", 8'h15, 8'h45);
    rd_chk("R7 other field", 8'h16, 8'h02);
  endtask

  task automatic t_alarm_basic();
    wr(8'h14, 8'h01);
    tick1();
    set_time(8'h00, 8'h04, 8'h59, 16'h0003);
    wr(8'h1A, 8'h05);
    rd_chk("R6 alarm minute readback", 8'h1A, 8'h05);
    wr(8'h14, 8'h0B);
    tick1();
    rd_chk("R9 flag set on match", 8'h14, 8'h0F);
    n_chk++;
    if (alarm_irq !== 1'b1) begin n_err++; $display("FAIL R11 irq got %b expected 1", alarm_irq); end
    wr(8'h14, 8'h0B);
    rd_chk("R10 write 0 keeps flag", 8'h14, 8'h0F);
    wr(8'h14, 8'h0F);
    rd_chk("R10 write 1 clears", 8'h14, 8'h0B);
    n_chk++;
    if (alarm_irq !== 1'b0) begin n_err++; $display("FAIL R11 irq got %b expected 0", alarm_irq); end
    tick1();
    rd_chk("R9 no re-set while match holds", 8'h14, 8'h0B);
  endtask

  task automatic t_alarm_gating();
    wr(8'h14, 8'h01);
    tick1();
    set_time(8'h00, 8'h04, 8'h59, 16'h0000);
    wr(8'h1A, 8'h05); wr(8'h1B, 8'h01);
    wr(8'h14, 8'h1B);
    tick1();
    rd_chk("R8 hour mismatch blocks", 8'h14, 8'h1B);
    wr(8'h14, 8'h03);
    tick1();
    rd_chk("R8 no enable no match", 8'h14, 8'h03);
    wr(8'h14, 8'h01);
    tick1();
    set_time(8'h23, 8'h59, 8'h59, 16'h0101);
    wr(8'h1C, 8'h02); wr(8'h1D, 8'h01);
    wr(8'h14, 8'h21);
    tick1();
    rd_chk("R8 day match sets flag", 8'h14, 8'h25);
    n_chk++;
    if (alarm_irq !== 1'b0) begin n_err++; $display("FAIL R11 irq masked got %b expected 0", alarm_irq); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stopped();
    t_bcd();
    t_cascade();
    t_busy_defer();
    t_alarm_basic();
    t_alarm_gating();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule